// File: doc/BRIEF.md
# Pulse Accumulator with Timer Clock Source Selection

This block keeps a 16-bit running count for a general-purpose timer. It has two counting modes. In event mode it counts one chosen edge of an external pin. In gated-time mode it counts a divide-by-64 tick from the timer prescaler, but only while the pin sits at its active level. Two sticky flags record accumulator wrap-around and input events. Each flag drives an interrupt output through its own enable.

The block also supplies the advance enable for the main timer counter. That enable comes from one of four sources: the prescaler tick, the accumulator input tick, the carry out of the accumulator's low byte, or the accumulator's full wrap. The control inputs are the outputs of a register that sits outside this block. A new source selection therefore shows on the tick output in the same cycle that the register presents it. Every divided clock is a one-cycle enable pulse in the system clock domain.

Top module: `pulse_accum_clksel`

## Requirements
- R1: In event mode (`mode_i`=0) the accumulator rises by one for each synchronized pin edge of the selected polarity: `edge_sel_i`=1 counts rising edges and `edge_sel_i`=0 counts falling edges. Edges of the other polarity do not change it.
- R2: In gated-time mode (`mode_i`=1) each cycle with `div64_tick_i` high adds one to the accumulator while the synchronized pin is high (`edge_sel_i`=0) or low (`edge_sel_i`=1). At the other pin level the accumulator holds.
- R3: With `tmr_en_i`=0, gated-time mode does not count, whatever `div64_tick_i` does.
- R4: `tcnt_tick_o` follows `clk_sel_i`: 00 gives `presc_tick_i`; 01 gives the accumulator increment pulse; 10 gives the carry out of bit MID_TAP-1 (divide by 256 by default); 11 gives the full wrap from all ones to zero.
- R5: With `acc_en_i`=0, `tcnt_tick_o` equals `presc_tick_i` for every `clk_sel_i`. The accumulator holds and no flag is set.
- R6: A change of `clk_sel_i` shows on `tcnt_tick_o` in the same cycle, with no added register stage.
- R7: A wrap of the accumulator from all ones to zero sets `ovf_flag_o`.
- R8: `inp_flag_o` is set by each selected edge in event mode. In gated-time mode it is set by the trailing edge of the active level: a falling edge when `edge_sel_i`=0, a rising edge when `edge_sel_i`=1.
- R9: `ovf_irq_o` is high only when `ovf_ie_i` and `ovf_flag_o` are both 1. `inp_irq_o` is high only when `inp_ie_i` and `inp_flag_o` are both 1.
- R10: A one-cycle pulse on `ovf_clr_i` or `inp_clr_i` clears that flag. If a set falls on the same cycle as a clear, the set wins.
- R11: After reset the accumulator is 0 and both flags and both interrupts are 0.
- R12: The pin passes through a synchronizer of SYNC_STAGES flops (default 2). A pin edge reaches the accumulator SYNC_STAGES+1 clock edges after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_en_i | input | 1 | Accumulator enable |
| mode_i | input | 1 | 0 event counting, 1 gated-time counting |
| edge_sel_i | input | 1 | Edge or active-level polarity select |
| clk_sel_i | input | 2 | Timer counter tick source select |
| ovf_ie_i | input | 1 | Overflow interrupt enable |
| inp_ie_i | input | 1 | Input-event interrupt enable |
| ovf_clr_i | input | 1 | Clear pulse for the overflow flag |
| inp_clr_i | input | 1 | Clear pulse for the input-event flag |
| pin_i | input | 1 | Raw asynchronous pin |
| presc_tick_i | input | 1 | Timer prescaler tick |
| div64_tick_i | input | 1 | Divide-by-64 tick from the prescaler |
| tmr_en_i | input | 1 | Timer enable |
| acc_o | output | ACC_W | Accumulator value |
| ovf_flag_o | output | 1 | Overflow flag |
| inp_flag_o | output | 1 | Input-event flag |
| ovf_irq_o | output | 1 | Overflow interrupt |
| inp_irq_o | output | 1 | Input-event interrupt |
| tcnt_tick_o | output | 1 | Advance enable for the main timer counter |

## Verification
The bench builds the block with its defaults: ACC_W=16, MID_TAP=8 and SYNC_STAGES=2. These are the widths at which the divide-by-256 and divide-by-65536 sources mean what their names say. In gated-time mode the bench holds the divide-by-64 tick high, so the accumulator advances once per cycle. A full 65536-step wrap then fits within the run, and the bench counts the byte-carry pulses against a model it computes itself. With two synchronizer stages, a pin edge lands three clock edges after it is driven. That lets the bench put a flag clear on exactly the cycle of a new set.

// File: rtl/pa_pkg.sv
package pa_pkg;
   typedef enum logic [1:0] {
      TSRC_PRESC = 2'b00,
      TSRC_ACCIN = 2'b01,
      TSRC_MID   = 2'b10,
      TSRC_WRAP  = 2'b11
   } tsrc_e;

   typedef enum logic {
      PA_EVENT = 1'b0,
      PA_GATED = 1'b1
   } pa_mode_e;
endpackage

// File: rtl/pa_sync_edge.sv
module pa_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[0] <= 1'b0;
            else         chain_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[s] <= 1'b0;
            else         chain_q[s] <= chain_q[s-1];
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= chain_q[STAGES-1];
   end

   assign level_o = chain_q[STAGES-1];
   assign rise_o  = chain_q[STAGES-1] & ~prev_q;
   assign fall_o  = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/pa_accum.sv
module pa_accum #(
   parameter int ACC_W   = 16,
   parameter int MID_TAP = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             inc_i,
   output logic [ACC_W-1:0] cnt_o,
   output logic             mid_carry_o,
   output logic             wrap_o
);
   logic [ACC_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    cnt_q <= '0;
      else if (inc_i) cnt_q <= cnt_q + 1'b1;
   end

   if (MID_TAP == ACC_W) begin : g_mid_full
      assign mid_carry_o = inc_i & (&cnt_q);
   end else begin : g_mid_part
      assign mid_carry_o = inc_i & (&cnt_q[MID_TAP-1:0]);
   end

   assign wrap_o = inc_i & (&cnt_q);
   assign cnt_o  = cnt_q;
endmodule

// File: rtl/pa_clk_sel.sv
module pa_clk_sel
   import pa_pkg::*;
(
   input  logic       acc_en_i,
   input  logic [1:0] sel_i,
   input  logic       presc_i,
   input  logic       accin_i,
   input  logic       mid_i,
   input  logic       wrap_i,
   output logic       tick_o
);
   always_comb begin
      tick_o = presc_i;
      if (acc_en_i) begin
         unique case (tsrc_e'(sel_i))
            TSRC_PRESC: tick_o = presc_i;
            TSRC_ACCIN: tick_o = accin_i;
            TSRC_MID:   tick_o = mid_i;
            TSRC_WRAP:  tick_o = wrap_i;
            default:    tick_o = presc_i;
         endcase
      end
   end
endmodule

// File: rtl/pulse_accum_clksel.sv
module pulse_accum_clksel
   import pa_pkg::*;
#(
   parameter int ACC_W       = 16,
   parameter int MID_TAP     = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             acc_en_i,
   input  logic             mode_i,
   input  logic             edge_sel_i,
   input  logic [1:0]       clk_sel_i,
   input  logic             ovf_ie_i,
   input  logic             inp_ie_i,
   input  logic             ovf_clr_i,
   input  logic             inp_clr_i,
   input  logic             pin_i,
   input  logic             presc_tick_i,
   input  logic             div64_tick_i,
   input  logic             tmr_en_i,
   output logic [ACC_W-1:0] acc_o,
   output logic             ovf_flag_o,
   output logic             inp_flag_o,
   output logic             ovf_irq_o,
   output logic             inp_irq_o,
   output logic             tcnt_tick_o
);
   localparam int NFLAG = 2;
   localparam int F_OVF = 0;
   localparam int F_INP = 1;

   if (ACC_W < 2) begin : g_bad_width
      $error("ACC_W must be at least 2");
   end
   if (MID_TAP < 1 || MID_TAP > ACC_W) begin : g_bad_tap
      $error("MID_TAP must lie in 1..ACC_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic     pin_lvl, pin_rise, pin_fall;
   logic     sel_edge, gate_open, gate_tick, in_tick;
   logic     acc_inc, mid_carry, wrap;
   logic     ovf_set, inp_set;
   pa_mode_e mode;

   pa_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .d_i     (pin_i),
      .level_o (pin_lvl),
      .rise_o  (pin_rise),
      .fall_o  (pin_fall)
   );

   assign mode      = pa_mode_e'(mode_i);
   // Selected edge in event mode; also the trailing edge of the active level.
   assign sel_edge  = edge_sel_i ? pin_rise : pin_fall;
   assign gate_open = edge_sel_i ? ~pin_lvl : pin_lvl;
   assign gate_tick = div64_tick_i & tmr_en_i & gate_open;
   assign in_tick   = (mode == PA_GATED) ? gate_tick : sel_edge;
   assign acc_inc   = acc_en_i & in_tick;

   pa_accum #(.ACC_W(ACC_W), .MID_TAP(MID_TAP)) u_acc (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .inc_i       (acc_inc),
      .cnt_o       (acc_o),
      .mid_carry_o (mid_carry),
      .wrap_o      (wrap)
   );

   pa_clk_sel u_csel (
      .acc_en_i (acc_en_i),
      .sel_i    (clk_sel_i),
      .presc_i  (presc_tick_i),
      .accin_i  (acc_inc),
      .mid_i    (mid_carry),
      .wrap_i   (wrap),
      .tick_o   (tcnt_tick_o)
   );

   assign ovf_set = wrap;
   assign inp_set = acc_en_i & sel_edge;

   logic [NFLAG-1:0] flag_q, flag_set, flag_clr, flag_ie;
   assign flag_set = {inp_set, ovf_set};
   assign flag_clr = {inp_clr_i, ovf_clr_i};
   assign flag_ie  = {inp_ie_i, ovf_ie_i};

   for (genvar f = 0; f < NFLAG; f++) begin : g_flag
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)          flag_q[f] <= 1'b0;
         else if (flag_set[f]) flag_q[f] <= 1'b1;
         else if (flag_clr[f]) flag_q[f] <= 1'b0;
      end
   end

   assign ovf_flag_o = flag_q[F_OVF];
   assign inp_flag_o = flag_q[F_INP];
   assign ovf_irq_o  = flag_q[F_OVF] & flag_ie[F_OVF];
   assign inp_irq_o  = flag_q[F_INP] & flag_ie[F_INP];
endmodule

// File: rtl/pa_accum_chk.sv
module pa_accum_chk #(
   parameter int ACC_W = 16
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             acc_en_i,
   input logic             mode_i,
   input logic             tmr_en_i,
   input logic             ovf_ie_i,
   input logic             inp_ie_i,
   input logic             ovf_clr_i,
   input logic             inp_clr_i,
   input logic             presc_tick_i,
   input logic [ACC_W-1:0] acc_o,
   input logic             ovf_flag_o,
   input logic             inp_flag_o,
   input logic             ovf_irq_o,
   input logic             inp_irq_o,
   input logic             tcnt_tick_o,
   input logic             acc_inc,
   input logic             ovf_set,
   input logic             inp_set
);
   p_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc_o != $past(acc_o)) |-> (acc_o == $past(acc_o) + 1'b1));

   p_notimer_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i && !tmr_en_i) |=> (acc_o == $past(acc_o)));

   p_hold_dis_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !acc_en_i |=> (acc_o == $past(acc_o)));

   p_presc_dis_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !acc_en_i |-> (tcnt_tick_o == presc_tick_i));

   p_wrap_ovf_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc_inc && (&acc_o)) |=> (ovf_flag_o && acc_o == '0));

   p_ovf_irq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_irq_o |-> (ovf_flag_o && ovf_ie_i));

   p_inp_irq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      inp_irq_o |-> (inp_flag_o && inp_ie_i));

   p_ovf_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovf_clr_i && !ovf_set) |=> !ovf_flag_o);

   p_inp_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inp_clr_i && !inp_set) |=> !inp_flag_o);

   p_inp_setwins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      inp_set |=> inp_flag_o);
endmodule

bind pulse_accum_clksel pa_accum_chk #(.ACC_W(ACC_W)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .acc_en_i     (acc_en_i),
   .mode_i       (mode_i),
   .tmr_en_i     (tmr_en_i),
   .ovf_ie_i     (ovf_ie_i),
   .inp_ie_i     (inp_ie_i),
   .ovf_clr_i    (ovf_clr_i),
   .inp_clr_i    (inp_clr_i),
   .presc_tick_i (presc_tick_i),
   .acc_o        (acc_o),
   .ovf_flag_o   (ovf_flag_o),
   .inp_flag_o   (inp_flag_o),
   .ovf_irq_o    (ovf_irq_o),
   .inp_irq_o    (inp_irq_o),
   .tcnt_tick_o  (tcnt_tick_o),
   .acc_inc      (acc_inc),
   .ovf_set      (ovf_set),
   .inp_set      (inp_set)
);

// File: tb/tb_pulse_accum_clksel.sv
module tb_pulse_accum_clksel;
   localparam int CLK_P = 10;
   localparam int ACC_W = 16;

   logic             clk_i = 1'b0;
   logic             rst_ni = 1'b0;
   logic             acc_en_i = 1'b0, mode_i = 1'b0, edge_sel_i = 1'b0;
   logic [1:0]       clk_sel_i = 2'b00;
   logic             ovf_ie_i = 1'b0, inp_ie_i = 1'b0;
   logic             ovf_clr_i = 1'b0, inp_clr_i = 1'b0;
   logic             pin_i = 1'b0, presc_tick_i = 1'b0, div64_tick_i = 1'b0;
   logic             tmr_en_i = 1'b1;
   logic [ACC_W-1:0] acc_o;
   logic             ovf_flag_o, inp_flag_o, ovf_irq_o, inp_irq_o, tcnt_tick_o;

   int checks = 0, errors = 0, tcnt_cnt = 0;
   int exp_acc = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk_i = ~clk_i;

   pulse_accum_clksel #(.ACC_W(ACC_W), .MID_TAP(8), .SYNC_STAGES(2)) dut (
      .clk_i(clk_i), .rst_ni(rst_ni), .acc_en_i(acc_en_i), .mode_i(mode_i),
      .edge_sel_i(edge_sel_i), .clk_sel_i(clk_sel_i), .ovf_ie_i(ovf_ie_i),
      .inp_ie_i(inp_ie_i), .ovf_clr_i(ovf_clr_i), .inp_clr_i(inp_clr_i),
      .pin_i(pin_i), .presc_tick_i(presc_tick_i), .div64_tick_i(div64_tick_i),
      .tmr_en_i(tmr_en_i), .acc_o(acc_o), .ovf_flag_o(ovf_flag_o),
      .inp_flag_o(inp_flag_o), .ovf_irq_o(ovf_irq_o), .inp_irq_o(inp_irq_o),
      .tcnt_tick_o(tcnt_tick_o)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // One cycle: sample tick output before the posedge, realign after the negedge.
   task automatic cyc();
      #2;
      if (tcnt_tick_o) tcnt_cnt++;
      @(negedge clk_i);
      #2;
   endtask

   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   task automatic pin_pulses(input int n);
      for (int i = 0; i < n; i++) begin
         pin_i = 1'b1; wait_n(4);
         pin_i = 1'b0; wait_n(4);
      end
   endtask

   task automatic tick_run(input int n);
      div64_tick_i = 1'b1;
      wait_n(n);
      div64_tick_i = 1'b0;
   endtask

   task automatic clr_inp();
      inp_clr_i = 1'b1; cyc(); inp_clr_i = 1'b0; cyc();
   endtask

   task automatic t_reset();
      chk("R11 acc after reset", acc_o, 0);
      chk("R11 ovf flag after reset", ovf_flag_o, 0);
      chk("R11 inp flag after reset", inp_flag_o, 0);
      chk("R11 irqs after reset", {ovf_irq_o, inp_irq_o}, 0);
   endtask

   task automatic t_event_rise();
      acc_en_i = 1'b1; mode_i = 1'b0; edge_sel_i = 1'b1; clk_sel_i = 2'b01;
      cyc();
      tcnt_cnt = 0;
      pin_pulses(5);
      exp_acc += 5;
      chk("R1 rising edges counted", acc_o, exp_acc);
      chk("R4 sel 01 follows input ticks", tcnt_cnt, 5);
      chk("R8 inp flag on event edge", inp_flag_o, 1);
      chk("R9 inp irq masked", inp_irq_o, 0);
      inp_ie_i = 1'b1; #1;
      chk("R9 inp irq enabled", inp_irq_o, 1);
      clr_inp();
      chk("R10 inp flag cleared", inp_flag_o, 0);
      chk("R9 inp irq drops with flag", inp_irq_o, 0);
   endtask

   task automatic t_event_fall();
      edge_sel_i = 1'b0; cyc();
      tcnt_cnt = 0;
      pin_pulses(3);
      exp_acc += 3;
      chk("R1 falling edges counted", acc_o, exp_acc);
      chk("R4 sel 01 on falling edges", tcnt_cnt, 3);
      clr_inp();
   endtask

   task automatic t_gated_high();
      mode_i = 1'b1; edge_sel_i = 1'b0;
      pin_i = 1'b1; wait_n(4);
      chk("R8 no flag on leading edge", inp_flag_o, 0);
      tcnt_cnt = 0;
      tick_run(10); cyc();
      exp_acc += 10;
      chk("R2 gated count while pin high", acc_o, exp_acc);
      chk("R4 sel 01 gated ticks", tcnt_cnt, 10);
      pin_i = 1'b0; wait_n(4);
      chk("R8 trailing fall sets flag", inp_flag_o, 1);
      chk("R2 trailing edge adds nothing", acc_o, exp_acc);
      tick_run(5); cyc();
      chk("R2 no count while pin low", acc_o, exp_acc);
      clr_inp();
   endtask

   task automatic t_gated_low();
      edge_sel_i = 1'b1; cyc();
      tick_run(7); cyc();
      exp_acc += 7;
      chk("R2 active-low gated count", acc_o, exp_acc);
      pin_i = 1'b1; wait_n(4);
      chk("R8 trailing rise sets flag", inp_flag_o, 1);
      tick_run(3); cyc();
      chk("R2 no count while pin high", acc_o, exp_acc);
      clr_inp();
   endtask

   task automatic t_timer_off();
      edge_sel_i = 1'b0; tmr_en_i = 1'b0; cyc();
      tcnt_cnt = 0;
      tick_run(6); cyc();
      chk("R3 timer off blocks gated count", acc_o, exp_acc);
      chk("R3 no ticks with timer off", tcnt_cnt, 0);
      tmr_en_i = 1'b1;
      pin_i = 1'b0; wait_n(4);
      clr_inp();
   endtask

   task automatic t_disabled();
      acc_en_i = 1'b0; mode_i = 1'b0; edge_sel_i = 1'b1; clk_sel_i = 2'b11;
      cyc();
      pin_pulses(2);
      chk("R5 acc holds when disabled", acc_o, exp_acc);
      chk("R5 no flag when disabled", inp_flag_o, 0);
      presc_tick_i = 1'b1; #2;
      chk("R5 prescaler tick passes", tcnt_tick_o, 1);
      @(negedge clk_i); #2;
      presc_tick_i = 1'b0; #2;
      chk("R5 prescaler low passes", tcnt_tick_o, 0);
      @(negedge clk_i); #2;
   endtask

   task automatic t_sel_now();
      acc_en_i = 1'b1; clk_sel_i = 2'b00; presc_tick_i = 1'b1; #2;
      chk("R4 sel 00 gives prescaler", tcnt_tick_o, 1);
      clk_sel_i = 2'b01; #1;
      chk("R6 new select shows at once", tcnt_tick_o, 0);
      @(negedge clk_i); #2;
      presc_tick_i = 1'b0;
   endtask

   task automatic t_set_wins();
      mode_i = 1'b0; edge_sel_i = 1'b1; cyc();
      pin_pulses(1);
      exp_acc += 1;
      chk("R8 flag set before clash", inp_flag_o, 1);
      pin_i = 1'b1;
      cyc();            // first sync stage
      cyc();            // second sync stage, edge seen
      inp_clr_i = 1'b1; // clear on the cycle of the new set
      cyc();
      inp_clr_i = 1'b0;
      exp_acc += 1;
      chk("R10 set wins over clear", inp_flag_o, 1);
      chk("R12 edge landed after sync", acc_o, exp_acc);
      pin_i = 1'b0; wait_n(4);
      clr_inp();
      chk("R10 clear without set", inp_flag_o, 0);
   endtask

   task automatic t_long_run();
      int a, exp_mid, rem;
      mode_i = 1'b1; edge_sel_i = 1'b0; clk_sel_i = 2'b10; ovf_ie_i = 1'b1;
      pin_i = 1'b1; wait_n(4);
      a = exp_acc; exp_mid = 0;
      for (int i = 0; i < 2000; i++) begin
         if ((a & 255) == 255) exp_mid++;
         a = (a + 1) & 16'hFFFF;
      end
      tcnt_cnt = 0;
      tick_run(2000); cyc();
      exp_acc = a;
      chk("R4 byte carries on sel 10", tcnt_cnt, exp_mid);
      chk("R4 acc after carries", acc_o, exp_acc);
      chk("R7 no overflow yet", ovf_flag_o, 0);
      clk_sel_i = 2'b11;
      rem = 65536 - exp_acc;
      tcnt_cnt = 0;
      tick_run(rem); cyc();
      chk("R4 one wrap tick on sel 11", tcnt_cnt, 1);
      chk("R7 acc wrapped to zero", acc_o, 0);
      chk("R7 overflow flag set", ovf_flag_o, 1);
      chk("R9 ovf irq asserted", ovf_irq_o, 1);
      ovf_clr_i = 1'b1; cyc(); ovf_clr_i = 1'b0; cyc();
      chk("R10 ovf flag cleared", ovf_flag_o, 0);
      chk("R9 ovf irq dropped", ovf_irq_o, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk_i);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog actual=expired expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk_i);
      rst_ni = 1'b1;
      @(negedge clk_i); #2;
      t_reset();
      t_event_rise();
      t_event_fall();
      t_gated_high();
      t_gated_low();
      t_timer_off();
      t_disabled();
      t_sel_now();
      t_set_wins();
      t_long_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule